// File: doc/BRIEF.md
# Configurable NaN Result Selector

This unit sits at the output stage of a two-operand binary32 adder or multiplier. It decides the result word whenever one or both operands are NaN. Each operand is classified as a number, a quiet NaN or a signalling NaN. A run-time policy input then picks which operand's payload is forwarded, or forces one fixed canonical NaN instead.

Any NaN that leaves the block is quiet. An invalid-operation flag reports every signalling input. The surrounding datapath supplies the arithmetic result for ordinary operands, so this block emits zero when neither operand is NaN. All outputs are registered and follow a valid strobe by one clock.

A NaN is a word whose 8-bit exponent field (bits 30:23) is all ones and whose 23-bit fraction (bits 22:0) is nonzero. Fraction bit 22 set means quiet, and clear means signalling. Policy codes on `mode_sel` are as follows:
- 0: operand A wins.
- 1: operand B wins.
- 2: stack rule.
- 3: signalling first.
- 4 to 7: canonical.

Top module: `nan_result_sel`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `nan_seen` is 1 exactly when at least one of `op_a` and `op_b` has exponent bits 30:23 all ones and a nonzero fraction in bits 22:0.
- R2: One clock after a valid cycle, `invalid_op` is 1 exactly when at least one operand is a signalling NaN (NaN with bit 22 equal to 0). This holds under every `mode_sel` value.
- R3: Under `mode_sel` 0 to 3, when exactly one operand is NaN, `result` is that operand, quieted.
- R4: Under `mode_sel` 0 with both operands NaN, `result` is `op_a` quieted, whatever the quiet or signalling state of either operand.
- R5: Under `mode_sel` 1 with both operands NaN, `result` is `op_b` quieted.
- R6: Under `mode_sel` 2 with both operands NaN, `result` is `op_a` quieted when `op_b` is signalling. Otherwise it is `op_b` quieted.
- R7: Under `mode_sel` 3 with both operands NaN, `result` is `op_b` quieted only when `op_b` is signalling and `op_a` is quiet. Otherwise it is `op_a` quieted.
- R8: Under `mode_sel` 4, 5, 6 or 7, every NaN result is 32'h7FC00000, regardless of the input payloads.
- R9: Quieting sets bit 22 and keeps every other bit, including the sign and the cause code in bits 2:0, so bits 2:0 of a propagated NaN equal those of the chosen operand.
- R10: When neither operand is NaN, `result` is 32'h00000000 and `nan_seen` is 0.
- R11: One clock after a cycle with `in_valid` low, `nan_seen` and `invalid_op` are 0 and `result` keeps its previous value.
- R12: A clock edge with `rst_n` low clears `nan_seen`, `invalid_op` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| mode_sel | input | 3 | Propagation policy code |
| nan_seen | output | 1 | Registered: at least one operand was NaN |
| result | output | 32 | Registered chosen result word |
| invalid_op | output | 1 | Registered: a signalling NaN was seen |

## Verification
Every one of the eight policy codes is driven with every pairing drawn from the following operands:
- quiet NaNs carrying distinct cause codes;
- signalling NaNs, including one whose only fraction bit is bit 0;
- an infinity, which must not count as NaN;
- an ordinary number.

The quiet/quiet, quiet/signalling, signalling/quiet and signalling/signalling pairs separate the four propagation rules from one another. The single-NaN pairs show that all non-canonical policies agree, and the payloads on both sides show which operand was forwarded and that its sign and low bits survive. Idle cycles between strobes and a reset in mid-run expose flags that stick, and a result register that changes without a strobe.

// File: rtl/nan_sel_pkg.sv
// Package: shared policy encoding and binary32 geometry for the NaN selector.
// Assumes IEEE 754 single-precision layout: sign, 8-bit exponent, 23-bit fraction.
package nan_sel_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    // Policy codes on the mode input; codes above CANON also mean canonical.
    typedef enum logic [2:0] {
        POL_A_WINS   = 3'd0,
        POL_B_WINS   = 3'd1,
        POL_STACK    = 3'd2,
        POL_SIG_PREF = 3'd3,
        POL_CANON    = 3'd4
    } policy_t;

    // Per-operand classification.
    typedef struct packed {
        logic is_nan;
        logic is_sig;
    } nan_class_t;

endpackage

// File: rtl/nan_classify.sv
// Module: nan_classify
// Classifies one floating-point word as NaN / signalling NaN.
// Assumes the exponent occupies the bits just below the sign and the fraction
// the low FRAC_W bits; the fraction MSB is the quiet bit.
module nan_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output nan_sel_pkg::nan_class_t cls
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;

    // Split the word into its fields and test them.
    always_comb begin
        exp_f      = word[WORD_W-2 -: EXP_W];
        frac_f     = word[FRAC_W-1:0];
        exp_ones   = &exp_f;
        cls.is_nan = exp_ones && (frac_f != '0);
        cls.is_sig = cls.is_nan && !frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/nan_policy_pick.sv
// Module: nan_policy_pick
// Decides, from the two operand classes and the policy code, whether operand B
// supplies the NaN payload and whether the canonical word replaces it.
// Assumes it is only meaningful when at least one operand is NaN.
module nan_policy_pick (
    input  nan_sel_pkg::nan_class_t cls_a,
    input  nan_sel_pkg::nan_class_t cls_b,
    input  logic [2:0]              mode,
    output logic                    take_b,
    output logic                    use_canon
);
    import nan_sel_pkg::*;

    logic both_nan;

    // Apply the selected two-NaN precedence rule.
    always_comb begin
        both_nan  = cls_a.is_nan && cls_b.is_nan;
        use_canon = (mode >= POL_CANON);
        take_b    = 1'b0;
        if (!both_nan) begin
            take_b = cls_b.is_nan;
        end else begin
            case (policy_t'(mode))
                POL_A_WINS:   take_b = 1'b0;
                POL_B_WINS:   take_b = 1'b1;
                POL_STACK:    take_b = !cls_b.is_sig;
                POL_SIG_PREF: take_b = cls_b.is_sig && !cls_a.is_sig;
                default:      take_b = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/nan_quieten.sv
// Module: nan_quieten
// Forces the quiet bit of a NaN word, keeping sign and all other payload bits.
// Assumes the input is a NaN; applied to a non-NaN it still just sets the bit.
module nan_quieten #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] nan_in,
    output logic [WORD_W-1:0] nan_out
);

    // Set the fraction MSB.
    always_comb begin
        nan_out           = nan_in;
        nan_out[FRAC_W-1] = 1'b1;
    end

endmodule

// File: rtl/nan_result_sel.sv
// Module: nan_result_sel (top)
// Picks the result of a two-operand binary32 operation when an operand is NaN,
// under a run-time propagation policy, and flags signalling inputs.
// Assumes the arithmetic path supplies non-NaN results elsewhere; here such a
// result is zero. Outputs register one clock after in_valid.
module nan_result_sel #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [2:0]        mode_sel,
    output logic              nan_seen,
    output logic [WORD_W-1:0] result,
    output logic              invalid_op
);
    import nan_sel_pkg::*;

    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] ops      [2];
    nan_class_t        cls      [2];
    logic [WORD_W-1:0] quiet_op [2];
    logic              take_b;
    logic              use_canon;
    logic              any_nan;
    logic              any_sig;
    logic [WORD_W-1:0] next_res;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One classifier and one quietener per operand.
    for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word (ops[gi]),
            .cls  (cls[gi])
        );
        nan_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
            .nan_in  (ops[gi]),
            .nan_out (quiet_op[gi])
        );
    end

    nan_policy_pick u_pick (
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .mode      (mode_sel),
        .take_b    (take_b),
        .use_canon (use_canon)
    );

    // Combine classes and form the next result word.
    always_comb begin
        any_nan = cls[0].is_nan || cls[1].is_nan;
        any_sig = cls[0].is_sig || cls[1].is_sig;
        if (!any_nan)
            next_res = '0;
        else if (use_canon)
            next_res = CANON_NAN;
        else
            next_res = take_b ? quiet_op[1] : quiet_op[0];
    end

    // Output registers: load on valid, flags drop when idle, result holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nan_seen   <= 1'b0;
            invalid_op <= 1'b0;
            result     <= '0;
        end else if (in_valid) begin
            nan_seen   <= any_nan;
            invalid_op <= any_sig;
            result     <= next_res;
        end else begin
            nan_seen   <= 1'b0;
            invalid_op <= 1'b0;
        end
    end

endmodule

// File: rtl/nan_result_sel_chk.sv
// Module: nan_result_sel_chk
// Port-level temporal checks for nan_result_sel, bound into every instance.
module nan_result_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [2:0]        mode_sel,
    input logic              nan_seen,
    input logic [WORD_W-1:0] result,
    input logic              invalid_op
);

    logic a_nan, b_nan, a_sig, b_sig;

    // Independent port-side classification.
    always_comb begin
        a_nan = (op_a[WORD_W-2 -: EXP_W] == '1) && (op_a[FRAC_W-1:0] != '0);
        b_nan = (op_b[WORD_W-2 -: EXP_W] == '1) && (op_b[FRAC_W-1:0] != '0);
        a_sig = a_nan && !op_a[FRAC_W-1];
        b_sig = b_nan && !op_b[FRAC_W-1];
    end

    // R11: idle cycle drops both flags
    p_idle_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!nan_seen && !invalid_op));

    // R11: idle cycle holds the result word
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R2: signalling input raises invalid flag
    p_sig_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_sig || b_sig)) |=> invalid_op);

    // R1: NaN flag follows NaN input
    p_nan_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (nan_seen == $past(a_nan || b_nan)));

    // R9: emitted NaN is quiet
    p_quiet_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nan_seen |-> (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1]));

    // R8: canonical policies emit the fixed word
    p_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[2] && (a_nan || b_nan)) |=>
        (result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

    // R9: cause bits survive propagation
    p_cause_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_sel[2] && (a_nan || b_nan)) |=>
        ((result[2:0] == $past(op_a[2:0])) || (result[2:0] == $past(op_b[2:0]))));

    // R10: non-NaN inputs give zero result
    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !a_nan && !b_nan) |=> (result == '0));

endmodule

bind nan_result_sel nan_result_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .mode_sel   (mode_sel),
    .nan_seen   (nan_seen),
    .result     (result),
    .invalid_op (invalid_op)
);

// File: tb/nan_result_sel_test.sv
// Bench for nan_result_sel: behavioural reference model compared every clock.
module nan_result_sel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  mode_sel = '0;
    logic        nan_seen;
    logic [31:0] result;
    logic        invalid_op;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    bit          m_nan = 0;
    bit          m_inv = 0;
    logic [31:0] m_res = '0;

    logic [31:0] pool [8] = '{32'h7FC00005, 32'h7F800003, 32'hFFC00001,
                              32'hFF812346, 32'h7F800001, 32'h7F800000,
                              32'h3F800000, 32'h7FE00007};

    always #2.5 clk = ~clk;

    nan_result_sel uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode_sel(mode_sel), .nan_seen(nan_seen), .result(result),
        .invalid_op(invalid_op)
    );

    function automatic bit f_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic bit f_sig(input logic [31:0] w);
        return f_nan(w) && (w[22] == 1'b0);
    endfunction

    function automatic string tag_for(input logic [31:0] a, input logic [31:0] b,
                                      input int m);
        if (!f_nan(a) && !f_nan(b)) return "R10";
        if (m >= 4) return "R8";
        if (!(f_nan(a) && f_nan(b))) return "R3";
        case (m)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference: what the block should output after this edge.
    task automatic model_edge();
        logic [31:0] pick;
        bit na, nb, sa, sb;
        if (!rst_n) begin
            m_nan = 0; m_inv = 0; m_res = 0;
            return;
        end
        if (!in_valid) begin
            m_nan = 0; m_inv = 0;
            return;
        end
        na = f_nan(op_a); nb = f_nan(op_b);
        sa = f_sig(op_a); sb = f_sig(op_b);
        m_nan = na | nb;
        m_inv = sa | sb;
        if (!na && !nb) pick = 32'h0;
        else if (mode_sel >= 4) pick = 32'h7FC00000;
        else if (na && !nb) pick = op_a | 32'h0040_0000;
        else if (nb && !na) pick = op_b | 32'h0040_0000;
        else begin
            int src; // 0 = A, 1 = B
            if (mode_sel == 0) src = 0;
            else if (mode_sel == 1) src = 1;
            else if (mode_sel == 2) src = sb ? 0 : 1;
            else src = (sb && !sa) ? 1 : 0;
            pick = (src == 0 ? op_a : op_b) | 32'h0040_0000;
        end
        m_res = pick;
    endtask

    task automatic compare(input string req);
        n_checks++;
        if (nan_seen !== m_nan || invalid_op !== m_inv || result !== m_res) begin
            n_fail++;
            $display("FAIL %s: got nan=%b inv=%b res=%h expected nan=%b inv=%b res=%h",
                     req, nan_seen, invalid_op, result, m_nan, m_inv, m_res);
        end
    endtask

    // One clock: inputs already driven at negedge; model at posedge; check after.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic drive(input bit v, input logic [31:0] a, input logic [31:0] b,
                         input int m);
        in_valid = v; op_a = a; op_b = b; mode_sel = m[2:0];
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        drive(1, 32'h7F800003, 32'h7FC00001, 0);
        step("R12");  // reset state held despite valid
        step("R12");
        rst_n = 1'b1;
        // Every policy code against every operand pair
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    drive(1, pool[i], pool[j], m);
                    step(tag_for(pool[i], pool[j], m));
                end
            end
        end
        // R9: sign and cause bits kept through quieting
        drive(1, 32'hFF800006, 32'h3F800000, 3);
        step("R9");
        // R11: idle cycles with changing inputs keep result, drop flags
        drive(0, 32'h7F800001, 32'h7F800002, 1);
        step("R11");
        drive(0, 32'h3F800000, 32'h7FC00000, 4);
        step("R11");
        // R2: invalid under canonical mode
        drive(1, 32'h40000000, 32'h7F8000AA, 5);
        step("R2");
        // R1: infinity pair is not NaN
        drive(1, 32'h7F800000, 32'hFF800000, 0);
        step("R1");
        // R12: mid-run reset clears outputs
        drive(1, 32'h7F800005, 32'h7F800002, 2);
        step("R6");
        rst_n = 1'b0;
        step("R12");
        rst_n = 1'b1;
        drive(1, 32'h7FC00004, 32'h7F800002, 3);
        step("R7");
        drive(0, 32'h0, 32'h0, 0);
        step("R11");
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule